// File: doc/BRIEF.md
# Multi-Edge Sample Word Detector

This block sits behind a 1:8 deserializer that turns a one-bit digitized signal into a word of eight consecutive samples on every fabric clock. The fabric clock cannot run at the sample rate, so one clock's word can hold several transitions. The block finds every rising and every falling transition inside each word. It carries the last sample of one word forward, so that a transition falling on the boundary between two words is still seen.

For every word the block reports a rising mask and a falling mask. It also reports the positions of the earliest and the latest transition, a flag that says whether there was any transition, and the number of transitions. Downstream trigger logic uses these values to act on more than one edge per clock without losing any of them.

The block also rebuilds a trigger word for an 8:1 output serializer. That word is the rising, falling or combined mask, chosen per word. It leaves the block after a fixed pipeline latency, with each bit still in the sample position where its transition occurred.

Top module: `edge_word_detect`

## Requirements
- R1: While `rst_n` is low, and until the first word presented after reset has been registered, every output is zero and the carried sample is 0.
- R2: Bit 0 of `samp_i` is the earliest sample of the word. `rise_o[i]` is 1 exactly when sample i is 1 and the sample before it is 0.
- R3: `fall_o[i]` is 1 exactly when sample i is 0 and the sample before it is 1. A bit is never set in both masks.
- R4: The predecessor of sample 0 is bit 7 of the previous word, so a transition between two words is reported at bit 0. After reset that predecessor is 0.
- R5: `cnt_o` is the number of set bits in `rise_o | fall_o`, from 0 to 8.
- R6: When at least one transition is present, `any_o` is 1 and `first_o`/`last_o` are the lowest and highest transition positions. When no transition is present, all three are 0.
- R7: The status outputs `rise_o`, `fall_o`, `first_o`, `last_o`, `cnt_o` and `any_o` describe the word presented one clock earlier.
- R8: `trig_o` equals the mask chosen by `tsel_i`, and appears exactly 8 clocks after its word is presented. The encodings are: 0 = rising, 1 = falling, 2 or 3 = both. `tsel_i` is sampled together with the same word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric clock, one sample word per cycle |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| samp_i | input | 8 | Sample word, bit 0 earliest |
| tsel_i | input | 2 | Trigger mask select for this word |
| rise_o | output | 8 | Rising-transition mask |
| fall_o | output | 8 | Falling-transition mask |
| first_o | output | 3 | Position of the earliest transition |
| last_o | output | 3 | Position of the latest transition |
| cnt_o | output | 4 | Transition count |
| any_o | output | 1 | At least one transition in the word |
| trig_o | output | 8 | Position-aligned trigger word for the serializer |

## Verification
The boundary assertion compares bit 0 of the masks against inputs from two clocks earlier. It therefore assumes that `samp_i` stays at 0 for the whole time the internal reset is held, because the cleared carried sample then agrees with the history the assertion sees. The stimulus drives `samp_i` and `tsel_i` to zero before and during reset and releases them only once the synchronized reset has been released. The other assertions relate the registered outputs to one another, and the stimulus can reach them with any word.

// File: rtl/edge_pkg.sv
package edge_pkg;
  typedef enum logic [1:0] {
    TSEL_RISE = 2'd0,
    TSEL_FALL = 2'd1,
    TSEL_BOTH = 2'd2,
    TSEL_ALL  = 2'd3
  } tsel_e;

  function automatic logic [7:0] pick_mask(input logic [1:0] sel,
                                           input logic [7:0] r,
                                           input logic [7:0] f);
    case (tsel_e'(sel))
      TSEL_RISE: pick_mask = r;
      TSEL_FALL: pick_mask = f;
      default:   pick_mask = r | f;
    endcase
  endfunction
endpackage

// File: rtl/edge_rst_sync.sv
module edge_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/edge_mask.sv
module edge_mask #(
  parameter int W = 8
) (
  input  logic [W-1:0] word,
  input  logic         prev,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] prior;

  assign prior = {word[W-2:0], prev};

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign rise[i] =  word[i] & ~prior[i];
    assign fall[i] = ~word[i] &  prior[i];
  end
endmodule

// File: rtl/edge_locate.sv
module edge_locate #(
  parameter int W  = 8,
  parameter int IW = $clog2(W),
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  tmask,
  output logic [IW-1:0] first,
  output logic [IW-1:0] last,
  output logic [CW-1:0] cnt,
  output logic          any
);
  always_comb begin
    first = '0;
    last  = '0;
    cnt   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (tmask[i]) first = IW'(i);
    end
    for (int i = 0; i < W; i++) begin
      if (tmask[i]) last = IW'(i);
      cnt = cnt + CW'(tmask[i]);
    end
  end

  assign any = |tmask;
endmodule

// File: rtl/edge_trig_delay.sv
module edge_trig_delay #(
  parameter int W   = 8,
  parameter int LAT = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage_q [LAT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= din;
  end

  for (genvar k = 1; k < LAT; k++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[k] <= '0;
      else        stage_q[k] <= stage_q[k-1];
    end
  end

  assign dout = stage_q[LAT-1];
endmodule

// File: rtl/edge_word_detect.sv
module edge_word_detect #(
  parameter int W   = 8,
  parameter int LAT = 8,
  localparam int IW = $clog2(W),
  localparam int CW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  samp_i,
  input  logic [1:0]    tsel_i,
  output logic [W-1:0]  rise_o,
  output logic [W-1:0]  fall_o,
  output logic [IW-1:0] first_o,
  output logic [IW-1:0] last_o,
  output logic [CW-1:0] cnt_o,
  output logic          any_o,
  output logic [W-1:0]  trig_o
);
  import edge_pkg::*;

  logic          srst_n;
  logic          prev_q, prev_d;
  logic [W-1:0]  rise_d, fall_d, rise_q, fall_q;
  logic [IW-1:0] first_d, last_d, first_q, last_q;
  logic [CW-1:0] cnt_d, cnt_q;
  logic          any_d, any_q;
  logic [W-1:0]  trig_d;

  edge_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(srst_n)
  );

  edge_mask #(.W(W)) u_mask (
    .word(samp_i), .prev(prev_q), .rise(rise_d), .fall(fall_d)
  );

  edge_locate #(.W(W), .IW(IW), .CW(CW)) u_loc (
    .tmask(rise_d | fall_d), .first(first_d), .last(last_d),
    .cnt(cnt_d), .any(any_d)
  );

  always_comb begin
    prev_d = samp_i[W-1];
    trig_d = W'(pick_mask(tsel_i, 8'(rise_d), 8'(fall_d)));
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      prev_q  <= 1'b0;
      rise_q  <= '0;
      fall_q  <= '0;
      first_q <= '0;
      last_q  <= '0;
      cnt_q   <= '0;
      any_q   <= 1'b0;
    end else begin
      prev_q  <= prev_d;
      rise_q  <= rise_d;
      fall_q  <= fall_d;
      first_q <= first_d;
      last_q  <= last_d;
      cnt_q   <= cnt_d;
      any_q   <= any_d;
    end
  end

  edge_trig_delay #(.W(W), .LAT(LAT)) u_dly (
    .clk(clk), .rst_n(srst_n), .din(trig_d), .dout(trig_o)
  );

  assign rise_o  = rise_q;
  assign fall_o  = fall_q;
  assign first_o = first_q;
  assign last_o  = last_q;
  assign cnt_o   = cnt_q;
  assign any_o   = any_q;

  // R3: no position is both a rising and a falling transition
  a_r3_disjoint: assert property (@(posedge clk) disable iff (!srst_n)
    (rise_o & fall_o) == '0);

  // R5: count agrees with the two masks
  a_r5_count: assert property (@(posedge clk) disable iff (!srst_n)
    cnt_o == CW'($countones(rise_o | fall_o)));

  // R6: reported positions are real transitions, ordered
  a_r6_positions: assert property (@(posedge clk) disable iff (!srst_n)
    any_o |-> ((rise_o[first_o] | fall_o[first_o]) &&
               (rise_o[last_o] | fall_o[last_o]) && first_o <= last_o));

  // R6: no transitions means zero positions
  a_r6_idle: assert property (@(posedge clk) disable iff (!srst_n)
    !any_o |-> (first_o == '0 && last_o == '0 && cnt_o == '0));

  // R4: boundary transition uses the previous word's last sample
  a_r4_boundary: assert property (@(posedge clk) disable iff (!srst_n)
    rise_o[0] |-> (!$past(samp_i[W-1], 2) && $past(samp_i[0])));
endmodule

// File: tb/edge_word_detect_test.sv
`timescale 1ns/1ps
module edge_word_detect_test;
  localparam int W   = 8;
  localparam int LAT = 8;
  localparam int N   = 1024;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] samp_i;
  logic [1:0] tsel_i;
  logic [7:0] rise_o, fall_o, trig_o;
  logic [2:0] first_o, last_o;
  logic [3:0] cnt_o;
  logic       any_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_trig [N + LAT + 2];

  always #2.5 clk = ~clk;

  edge_word_detect #(.W(W), .LAT(LAT)) uut (
    .clk(clk), .rst_n(rst_n), .samp_i(samp_i), .tsel_i(tsel_i),
    .rise_o(rise_o), .fall_o(fall_o), .first_o(first_o), .last_o(last_o),
    .cnt_o(cnt_o), .any_o(any_o), .trig_o(trig_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected status for word w following sample p
  task automatic check_status(input logic [7:0] w, input logic p);
    logic [7:0] r, f, m;
    int fi, la, c;
    logic pr;
    pr = p; r = '0; f = '0;
    for (int i = 0; i < 8; i++) begin
      r[i] = w[i] & ~pr;
      f[i] = ~w[i] & pr;
      pr = w[i];
    end
    m = r | f; fi = 0; la = 0; c = 0;
    for (int i = 0; i < 8; i++) if (m[i]) c++;
    for (int i = 7; i >= 0; i--) if (m[i]) fi = i;
    for (int i = 0; i < 8; i++) if (m[i]) la = i;
    chk("R2 rise", rise_o, r);
    chk("R3 fall", fall_o, f);
    chk("R5 count", cnt_o, c);
    chk("R6 any", any_o, m != 0);
    chk("R6 first", first_o, fi);
    chk("R6 last", last_o, la);
  endtask

  function automatic logic [7:0] sel_mask(input logic [7:0] w, input logic p,
                                          input logic [1:0] s);
    logic [7:0] r, f;
    logic pr;
    pr = p; r = '0; f = '0;
    for (int i = 0; i < 8; i++) begin
      r[i] = w[i] & ~pr;
      f[i] = ~w[i] & pr;
      pr = w[i];
    end
    return (s == 2'd0) ? r : (s == 2'd1) ? f : (r | f);
  endfunction

  initial begin
    #(5ns * 200000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] last_w;
    logic [7:0] cur_w;
    logic       p;
    rst_n = 1'b0; samp_i = '0; tsel_i = '0;
    repeat (3) @(negedge clk);
    // R1: outputs cleared while reset held
    chk("R1 rise", rise_o, 0); chk("R1 fall", fall_o, 0);
    chk("R1 cnt", cnt_o, 0); chk("R1 any", any_o, 0);
    chk("R1 trig", trig_o, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 idle", {rise_o, fall_o, trig_o}, 0);

    p = 1'b0; last_w = '0;
    for (int i = 0; i < N + LAT + 1; i++) begin
      if (i >= 1) begin
        // R7: status reflects word of previous clock; R4 via carried p
        check_status(last_w, p);
        p = last_w[7];
      end
      // R8: trigger of word presented LAT clocks earlier
      if (i >= LAT) chk("R8 trig", trig_o, exp_trig[i - LAT]);
      else          chk("R1 trig pipe", trig_o, 0);
      if (i < N) begin
        cur_w  = 8'((i * 37) + ((i >> 8) * 101));
        tsel_i = 2'(i >> 8);
      end else begin
        cur_w  = 8'h00;
        tsel_i = 2'd2;
      end
      // R4: first word after reset sees predecessor 0
      exp_trig[i] = sel_mask(cur_w, (i == 0) ? 1'b0 : last_w[7], tsel_i);
      samp_i = cur_w;
      last_w = cur_w;
      @(negedge clk);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule